// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the final output word of an ADC accumulator and raises a sticky flag when that word lies in a programmed region. Two 16-bit limit registers are held inside the block: an upper-side "above" limit and a lower-side "below" limit. Software loads each one through its own write strobe.

The detection region is chosen by how the two limits compare. When the below limit is numerically larger than the above limit, a hit means the word lies strictly between them (inside detection). Otherwise a hit means the word lies strictly under the below limit or strictly over the above limit (outside detection).

The word is compared exactly as it is presented, so right-justified and left-justified formats are both handled by choosing suitable limits. A comparison happens only when the done strobe marks a completed, fully accumulated result. The flag stays set until software clears it. An interrupt request is the flag gated by an enable input.

Top module: `adc_window_watch`

## Requirements
- R1: After reset the flag and interrupt request are 0, the above limit is 0xFFFF and the below limit is 0x0000. With these limits no result word, including 0x0000 and 0xFFFF, sets the flag.
- R2: When below limit > above limit, a strobed word W sets the flag if and only if above < W < below, with both comparisons strict.
- R3: When below limit <= above limit, a strobed word W sets the flag if and only if W < below or W > above, with both comparisons strict.
- R4: A word is compared only in a cycle where `res_done` is 1. Words presented without the strobe never change the flag.
- R5: Once set, the flag stays 1 through later non-matching results until a software clear.
- R6: `sw_clr` makes the flag 0 after the next clock edge. If a clear and a matching strobed result fall in the same cycle, the flag is 1 after that edge.
- R7: `win_irq` is 1 exactly when the flag is 1 and `irq_en` is 1. This is combinational, with no added delay.
- R8: A limit write takes effect at the clock edge where its strobe is sampled. A result strobed in that same cycle is compared against the old limit value.
- R9: The flag reflects a strobed result after the clock edge at which `res_done` is sampled, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_word | input | 16 | Final formatted ADC output word |
| res_done | input | 1 | Strobe: res_word is a completed accumulated result |
| above_wr | input | 1 | Load strobe for the above limit |
| above_data | input | 16 | New above-limit value |
| below_wr | input | 1 | Load strobe for the below limit |
| below_data | input | 16 | New below-limit value |
| sw_clr | input | 1 | Software clear of the flag |
| irq_en | input | 1 | Interrupt enable |
| win_flag | output | 1 | Sticky window-hit flag |
| win_irq | output | 1 | Interrupt request |

## Verification
The flag and the limit registers are due one clock edge after their strobe is sampled. The interrupt request follows the flag and the enable in the same cycle. The bench drives every input on the falling edge and holds it across exactly one rising edge. It then reads the flag on the following falling edge, so each result is checked in the first cycle it can be visible. Limit pairs are swept over both inside and outside orderings, including equal limits and limits at the ends of the range. Each pair is probed at the words just below, at and just above both limits, and the expected hit is computed arithmetically in the bench.

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_word,
  input  logic         res_done,
  input  logic         above_wr,
  input  logic [W-1:0] above_data,
  input  logic         below_wr,
  input  logic [W-1:0] below_data,
  input  logic         sw_clr,
  input  logic         irq_en,
  output logic         win_flag,
  output logic         win_irq
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] above_q, below_q;
  logic         inside_mode, hit_in, hit_out, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      above_q <= ALL_ONES;
      below_q <= '0;
    end else begin
      if (above_wr) above_q <= above_data;
      if (below_wr) below_q <= below_data;
    end

  assign inside_mode = below_q > above_q;
  assign hit_in      = (res_word > above_q) && (res_word < below_q);
  assign hit_out     = (res_word < below_q) || (res_word > above_q);
  assign hit         = res_done && (inside_mode ? hit_in : hit_out);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      win_flag <= 1'b0;
    else if (hit)    win_flag <= 1'b1;
    else if (sw_clr) win_flag <= 1'b0;

  assign win_irq = win_flag & irq_en;
endmodule

module adc_window_watch_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] res_word,
  input logic         res_done,
  input logic         sw_clr,
  input logic         irq_en,
  input logic [W-1:0] above_q,
  input logic [W-1:0] below_q,
  input logic         win_flag,
  input logic         win_irq
);
  a_r4_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_done && !sw_clr) |=> $stable(win_flag));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !sw_clr) |=> win_flag);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !res_done) |=> !win_flag);
  a_r2_inside_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && below_q > above_q && res_word > above_q && res_word < below_q) |=> win_flag);
  a_r3_outside_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && below_q <= above_q && (res_word < below_q || res_word > above_q)) |=> win_flag);
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq |-> (win_flag && irq_en));
  a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && irq_en) |-> win_irq);
endmodule

bind adc_window_watch adc_window_watch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_done(res_done),
  .sw_clr(sw_clr), .irq_en(irq_en), .above_q(above_q), .below_q(below_q),
  .win_flag(win_flag), .win_irq(win_irq)
);

// File: tb/tb_adc_window_watch.sv
module tb_adc_window_watch;
  logic clk = 0, rst_n = 0;
  logic [15:0] res_word = 0, above_data = 0, below_data = 0;
  logic res_done = 0, above_wr = 0, below_wr = 0, sw_clr = 0, irq_en = 0;
  logic win_flag, win_irq;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_window_watch dut (.*);

  function automatic bit exp_hit(logic [15:0] ab, logic [15:0] be, logic [15:0] w);
    if (be > ab) return (w > ab) && (w < be);
    return (w < be) || (w > ab);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic set_limits(logic [15:0] ab, logic [15:0] be);
    @(negedge clk); above_wr = 1; below_wr = 1; above_data = ab; below_data = be;
    @(negedge clk); above_wr = 0; below_wr = 0;
  endtask

  task automatic strobe(logic [15:0] w, bit clr);
    @(negedge clk); res_word = w; res_done = 1; sw_clr = clr;
    @(negedge clk); res_done = 0; sw_clr = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); sw_clr = 1;
    @(negedge clk); sw_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] pa [8];
    logic [15:0] pb [8];
    pa = '{16'h0100, 16'h0000, 16'hFFFD, 16'h7FF0, 16'h0200, 16'h0300, 16'h0000, 16'hFFF0};
    pb = '{16'h0200, 16'h0002, 16'hFFFF, 16'h8010, 16'h0100, 16'h0300, 16'hFFFF, 16'h0010};
    repeat (3) @(negedge clk);
    chk("R1 reset flag", win_flag, 0);
    chk("R1 reset irq", win_irq, 0);
    rst_n = 1;
    irq_en = 1;
    // R1: default limits never match
    strobe(16'h0000, 0); chk("R1 default 0x0000", win_flag, 0);
    strobe(16'hFFFF, 0); chk("R1 default 0xFFFF", win_flag, 0);
    strobe(16'h8000, 0); chk("R1 default 0x8000", win_flag, 0);
    // R2 / R3 / R9 sweep
    for (int p = 0; p < 8; p++) begin
      logic [15:0] pts [8];
      set_limits(pa[p], pb[p]);
      pts = '{pa[p] - 16'd1, pa[p], pa[p] + 16'd1, pb[p] - 16'd1, pb[p], pb[p] + 16'd1,
              16'h0000, 16'hFFFF};
      for (int i = 0; i < 8; i++) begin
        clear_flag();
        strobe(pts[i], 0);
        chk((pb[p] > pa[p]) ? "R2 inside sweep R9" : "R3 outside sweep R9",
            win_flag, exp_hit(pa[p], pb[p], pts[i]));
      end
    end
    // R4: matching word without strobe
    set_limits(16'h0100, 16'h0200);
    clear_flag();
    @(negedge clk); res_word = 16'h0180;
    repeat (3) @(negedge clk);
    chk("R4 no strobe", win_flag, 0);
    // R5 sticky
    strobe(16'h0180, 0); chk("R5 set", win_flag, 1);
    strobe(16'h0050, 0); chk("R5 sticky after miss", win_flag, 1);
    // R7 irq gating
    irq_en = 0; #1; chk("R7 irq off", win_irq, 0);
    irq_en = 1; #1; chk("R7 irq on", win_irq, 1);
    // R6 clear, and clear with simultaneous match
    clear_flag(); chk("R6 clear", win_flag, 0);
    chk("R7 irq follows clear", win_irq, 0);
    strobe(16'h0150, 1); chk("R6 match beats clear", win_flag, 1);
    strobe(16'h0010, 1); chk("R6 clear with miss", win_flag, 0);
    // R8: limit write and strobe in same cycle uses old limits (inside 0x100..0x200)
    @(negedge clk); above_wr = 1; above_data = 16'h0180; res_word = 16'h0150; res_done = 1;
    @(negedge clk); above_wr = 0; res_done = 0;
    chk("R8 old limit used", win_flag, 1);
    clear_flag();
    strobe(16'h0150, 0); chk("R8 new limit active", win_flag, 0);
    finish_run();
  end
endmodule